// File: doc/BRIEF.md
# Piecewise Quadratic Square-Root Approximator

This block returns an approximate square root of an unsigned fixed-point argument. It does not use an exact root unit. It splits the supported argument interval into a power-of-two number of equal segments. Each segment has a centre point and three stored coefficients. The root is evaluated as a second-order expansion about the centre of the segment that holds the argument. The unit is meant for phase-compensation datapaths, where a wider-precision front end supplies a normalised argument. Over the narrow argument band that moderate squint angles produce, a short polynomial gives enough accuracy.

The argument `in_arg` has 16 bits and 14 fraction bits, so its value is `in_arg / 16384`. The supported interval is [1.0, 2.0). It is split into 16 segments. The segment number comes straight from the four bits just below the integer bit. The ten bits under those give the offset from the segment centre. The root `out_root` has 15 fraction bits.

The segment number, the offset and the three coefficients are also brought out one cycle after the argument is accepted. A second compensation path can then use the same index logic and coefficient storage without its own copy. The coefficients have 20 fraction bits and are computed from the segment centres when the design is elaborated.

Top module: `sqrt_taylor_top`

## Requirements
- R1: `out_valid` rises exactly four clock edges after the edge at which `in_valid` was sampled high. Each valid result belongs to that accepted argument.
- R2: For every argument in [16384, 32767], `|out_root/32768 - sqrt(in_arg/16384)|` is below 2^-15.
- R3: For an in-range argument, `lk_valid` is high one edge after acceptance and `lk_seg` equals `in_arg[13:10]`.
- R4: For an in-range argument, `lk_off` is the signed value `in_arg[9:0] - 512`, in the range -512 to 511.
- R5: An argument below 16384 is handled as 1.0: `lk_seg` is 0, `lk_off` is -512, and the root is within 2^-15 of 1.0. An argument of 32768 or more is handled as 32767/16384: `lk_seg` is 15, `lk_off` is 511, and the root is within 2^-15 of sqrt(32767/16384). No argument wraps into another segment.
- R6: Let m = 1 + (lk_seg + 0.5)/16. Then `lk_c0` is within 1 of sqrt(m)·2^20, `lk_c1` is within 2 of 2^20/(2·sqrt(m)), and `lk_c2` is within 2 of -2^20/(8·m·sqrt(m)).
- R7: One argument is accepted on every cycle that `in_valid` is high, with no stall. Results leave in arrival order with the same gap pattern, and every accepted argument gives exactly one result.
- R8: While the synchronous active-high `rst` is high, and after it is released, no valid strobe appears for arguments that were in flight when reset was raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Argument strobe |
| in_arg | input | 16 | Unsigned argument, 14 fraction bits |
| out_valid | output | 1 | Root strobe |
| out_root | output | 16 | Approximate root, 15 fraction bits |
| lk_valid | output | 1 | Shared lookup strobe |
| lk_seg | output | 4 | Shared segment number |
| lk_off | output | 11 | Shared signed offset from segment centre |
| lk_c0 | output | 24 | Shared constant coefficient |
| lk_c1 | output | 24 | Shared linear coefficient |
| lk_c2 | output | 24 | Shared quadratic coefficient |

## Verification
The hardest cases to reach are the worst-case accuracy points and the saturation boundaries. The worst-case accuracy points sit at the outer edge of each segment, where the cubic remainder is largest. The saturation boundaries are the values just below 1.0 and from 2.0 upward. The bench walks all 65536 argument codes in order, so every segment edge, both clamp thresholds and the codes far outside the interval are each driven once. Idle cycles are placed at irregular points in the sweep, so the result stream also has to keep its gap pattern. A reset raised while arguments are still in flight shows that pending strobes are dropped.

// File: rtl/sqt_pkg.sv
package sqt_pkg;

    localparam int IN_W      = 16;
    localparam int FRAC      = 14;
    localparam int SEG_BITS  = 4;
    localparam int SEGS      = 1 << SEG_BITS;
    localparam int LOW_W     = FRAC - SEG_BITS;
    localparam int OFF_W     = LOW_W + 1;
    localparam int COEF_FRAC = 20;
    localparam int COEF_W    = 24;
    localparam int OUT_W     = 16;
    localparam int OUT_FRAC  = 15;
    localparam int SQ_W      = 2 * OFF_W;
    localparam int T1_W      = COEF_W + OFF_W;
    localparam int T2_W      = COEF_W + SQ_W;
    localparam int ACC_W     = 56;
    localparam int SHIFT     = COEF_FRAC + 2 * FRAC - OUT_FRAC;

    typedef logic [SEG_BITS-1:0]      seg_t;
    typedef logic signed [OFF_W-1:0]  off_t;
    typedef logic signed [COEF_W-1:0] coef_w_t;

    localparam logic [IN_W-1:0] ARG_ONE  = IN_W'(1) << FRAC;
    localparam logic [IN_W-1:0] ARG_TWO  = IN_W'(1) << (FRAC + 1);
    localparam off_t            OFF_HALF = off_t'(1) <<< (LOW_W - 1);

    typedef struct packed {
        coef_w_t c0;
        coef_w_t c1;
        coef_w_t c2;
    } coef_t;

    typedef struct packed {
        logic                    valid;
        coef_w_t                 c0;
        coef_w_t                 c2;
        logic signed [T1_W-1:0]  t1;
        logic signed [SQ_W-1:0]  dsq;
    } st2_t;

    typedef struct packed {
        logic                    valid;
        coef_w_t                 c0;
        logic signed [T1_W-1:0]  t1;
        logic signed [T2_W-1:0]  t2;
    } st3_t;

    // floor of the square root, bit-pair method
    function automatic longint int_sqrt(longint v);
        longint n;
        longint r;
        longint b;
        n = v;
        r = 0;
        b = longint'(1) << 62;
        for (int i = 0; i < 32; i++) begin
            if (n >= r + b) begin
                n = n - (r + b);
                r = (r >> 1) + b;
            end else begin
                r = r >> 1;
            end
            b = b >> 2;
        end
        return r;
    endfunction

    // coefficients of the expansion about the centre of segment k
    function automatic coef_t coef_for(int k);
        longint m;
        longint c0;
        longint c1;
        longint c2;
        longint den;
        coef_t  res;
        m   = (longint'(1) << FRAC) + (longint'(k) << LOW_W) + (longint'(1) << (LOW_W - 1));
        c0  = int_sqrt(m << (2 * COEF_FRAC - FRAC));
        c1  = ((longint'(1) << (2 * COEF_FRAC)) + c0) / (2 * c0);
        den = 8 * m * c0;
        c2  = -(((longint'(1) << (2 * COEF_FRAC + FRAC)) + den / 2) / den);
        res.c0 = COEF_W'(c0);
        res.c1 = COEF_W'(c1);
        res.c2 = COEF_W'(c2);
        return res;
    endfunction

endpackage

// File: rtl/sqt_segmenter.sv
module sqt_segmenter
    import sqt_pkg::*;
(
    input  logic [IN_W-1:0] arg,
    output seg_t            seg,
    output off_t            off
);

    always_comb begin
        if (arg < ARG_ONE) begin
            seg = '0;
            off = -OFF_HALF;
        end else if (arg >= ARG_TWO) begin
            seg = '1;
            off = OFF_HALF - off_t'(1);
        end else begin
            seg = arg[FRAC-1 -: SEG_BITS];
            off = off_t'({1'b0, arg[LOW_W-1:0]}) - OFF_HALF;
        end
    end

endmodule

// File: rtl/sqt_lookup.sv
module sqt_lookup
    import sqt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  seg_t  seg_in,
    input  off_t  off_in,
    output logic  valid_q,
    output seg_t  seg_q,
    output off_t  off_q,
    output coef_t coef_q
);

    coef_t table_w [SEGS];

    for (genvar g = 0; g < SEGS; g++) begin : g_rom
        assign table_w[g] = coef_for(g);
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        seg_q  <= seg_in;
        off_q  <= off_in;
        coef_q <= table_w[seg_in];
    end

endmodule

// File: rtl/sqt_poly_pipe.sv
module sqt_poly_pipe
    import sqt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  off_t             off,
    input  coef_t            coef,
    output logic             out_valid,
    output logic [OUT_W-1:0] root
);

    localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1) <<< (SHIFT - 1);
    localparam logic signed [ACC_W-1:0] ACC_LO = ACC_W'((1 << OUT_FRAC) - 1) <<< SHIFT;
    localparam logic signed [ACC_W-1:0] ACC_HI = ACC_W'(3 << (OUT_FRAC - 1)) <<< SHIFT;

    st2_t s2;
    st3_t s3;
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = (ACC_W'(s3.c0) <<< (2 * FRAC))
            + (ACC_W'(s3.t1) <<< FRAC)
            + ACC_W'(s3.t2)
            + RND;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2        <= '0;
            s3        <= '0;
            out_valid <= 1'b0;
            root      <= '0;
        end else begin
            s2.valid  <= in_valid;
            s2.c0     <= coef.c0;
            s2.c2     <= coef.c2;
            s2.t1     <= T1_W'(coef.c1) * T1_W'(off);
            s2.dsq    <= SQ_W'(off) * SQ_W'(off);
            s3.valid  <= s2.valid;
            s3.c0     <= s2.c0;
            s3.t1     <= s2.t1;
            s3.t2     <= T2_W'(s2.c2) * T2_W'(s2.dsq);
            out_valid <= s3.valid;
            root      <= acc[SHIFT +: OUT_W];
        end
    end

    // R2: the pre-rounding sum stays inside [1, 1.5) of the root scale
    assert_sum_window_R2: assert property (@(posedge clk) disable iff (rst)
        s3.valid |-> ((acc >= ACC_LO) && (acc < ACC_HI)));

    // R2: the squared offset never goes negative
    assert_square_sign_R2: assert property (@(posedge clk) disable iff (rst)
        s2.valid |-> (s2.dsq >= 0));

endmodule

// File: rtl/sqrt_taylor_top.sv
module sqrt_taylor_top
    import sqt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [IN_W-1:0]          in_arg,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_root,
    output logic                     lk_valid,
    output logic [SEG_BITS-1:0]      lk_seg,
    output logic signed [OFF_W-1:0]  lk_off,
    output logic signed [COEF_W-1:0] lk_c0,
    output logic signed [COEF_W-1:0] lk_c1,
    output logic signed [COEF_W-1:0] lk_c2
);

    seg_t  seg_c;
    off_t  off_c;
    seg_t  seg_q;
    off_t  off_q;
    coef_t coef_q;
    logic  valid_q;

    sqt_segmenter u_seg (
        .arg (in_arg),
        .seg (seg_c),
        .off (off_c)
    );

    sqt_lookup u_lookup (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .seg_in   (seg_c),
        .off_in   (off_c),
        .valid_q  (valid_q),
        .seg_q    (seg_q),
        .off_q    (off_q),
        .coef_q   (coef_q)
    );

    sqt_poly_pipe u_poly (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (valid_q),
        .off       (off_q),
        .coef      (coef_q),
        .out_valid (out_valid),
        .root      (out_root)
    );

    assign lk_valid = valid_q;
    assign lk_seg   = seg_q;
    assign lk_off   = off_q;
    assign lk_c0    = coef_q.c0;
    assign lk_c1    = coef_q.c1;
    assign lk_c2    = coef_q.c2;

    // acceptance history, used by the latency property only
    logic [3:0] vhist;
    always_ff @(posedge clk) begin
        if (rst) vhist <= '0;
        else     vhist <= {vhist[2:0], in_valid};
    end

    logic in_rng;
    assign in_rng = (in_arg >= ARG_ONE) && (in_arg < ARG_TWO);

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid == vhist[3]);

    assert_seg_from_arg_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_rng) |=> (lk_valid && lk_seg == $past(in_arg[FRAC-1 -: SEG_BITS])));

    assert_offset_span_R4: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> ((lk_off >= -OFF_HALF) && (lk_off < OFF_HALF)));

    assert_clamp_low_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_arg < ARG_ONE) |=> (lk_seg == '0 && lk_off == -OFF_HALF));

    assert_clamp_high_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_arg >= ARG_TWO) |=> (lk_seg == '1 && lk_off == OFF_HALF - off_t'(1)));

    assert_root_span_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_root >= OUT_W'((1 << OUT_FRAC) - 1)) && (out_root <= OUT_W'(46342))));

endmodule

// File: tb/sqrt_taylor_top_bench.sv
module sqrt_taylor_top_bench;
    import sqt_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     in_valid = 1'b0;
    logic [15:0]              in_arg = '0;
    logic                     out_valid;
    logic [15:0]              out_root;
    logic                     lk_valid;
    logic [3:0]               lk_seg;
    logic signed [10:0]       lk_off;
    logic signed [23:0]       lk_c0;
    logic signed [23:0]       lk_c1;
    logic signed [23:0]       lk_c2;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_in = 0;
    int n_out = 0;
    bit done = 1'b0;

    int qo_arg[$];
    int qo_cyc[$];
    int ql_arg[$];
    int ql_cyc[$];

    sqrt_taylor_top u_sqrt_taylor_top (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_arg    (in_arg),
        .out_valid (out_valid),
        .out_root  (out_root),
        .lk_valid  (lk_valid),
        .lk_seg    (lk_seg),
        .lk_off    (lk_off),
        .lk_c0     (lk_c0),
        .lk_c1     (lk_c1),
        .lk_c2     (lk_c2)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic real absr(real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic check(bit ok, string req, string what, real act, real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
        end
    endtask

    task automatic send(int x);
        @(negedge clk);
        in_valid = 1'b1;
        in_arg   = 16'(x);
        qo_arg.push_back(x);
        qo_cyc.push_back(cyc);
        ql_arg.push_back(x);
        ql_cyc.push_back(cyc);
        n_in++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: two time units after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (lk_valid) begin
                if (ql_arg.size() == 0) begin
                    check(1'b0, "R7", "lookup strobe without input", 1.0, 0.0);
                end else begin
                    int  a;
                    int  c;
                    int  es;
                    int  eo;
                    real m;
                    a = ql_arg.pop_front();
                    c = ql_cyc.pop_front();
                    check(cyc == c + 1, "R3", "lookup cycle", real'(cyc), real'(c + 1));
                    if (a < 16384) begin
                        es = 0; eo = -512;
                    end else if (a >= 32768) begin
                        es = 15; eo = 511;
                    end else begin
                        es = (a >> 10) & 15; eo = (a & 1023) - 512;
                    end
                    check(int'(lk_seg) == es, (a < 16384 || a >= 32768) ? "R5" : "R3",
                          "segment", real'(lk_seg), real'(es));
                    check(int'(lk_off) == eo, (a < 16384 || a >= 32768) ? "R5" : "R4",
                          "offset", real'(lk_off), real'(eo));
                    m = 1.0 + (real'(lk_seg) + 0.5) / 16.0;
                    check(absr(real'(lk_c0) - $sqrt(m) * 1048576.0) <= 1.0, "R6", "c0",
                          real'(lk_c0), $sqrt(m) * 1048576.0);
                    check(absr(real'(lk_c1) - 1048576.0 / (2.0 * $sqrt(m))) <= 2.0, "R6", "c1",
                          real'(lk_c1), 1048576.0 / (2.0 * $sqrt(m)));
                    check(absr(real'(lk_c2) + 1048576.0 / (8.0 * m * $sqrt(m))) <= 2.0, "R6", "c2",
                          real'(lk_c2), -1048576.0 / (8.0 * m * $sqrt(m)));
                end
            end
            if (out_valid) begin
                if (qo_arg.size() == 0) begin
                    check(1'b0, "R7", "result strobe without input", 1.0, 0.0);
                end else begin
                    int  a;
                    int  c;
                    real xc;
                    real want;
                    real got;
                    a = qo_arg.pop_front();
                    c = qo_cyc.pop_front();
                    n_out++;
                    check(cyc == c + 4, "R1", "result cycle", real'(cyc), real'(c + 4));
                    if (a < 16384)       xc = 1.0;
                    else if (a >= 32768) xc = 32767.0 / 16384.0;
                    else                 xc = real'(a) / 16384.0;
                    want = $sqrt(xc);
                    got  = real'(out_root) / 32768.0;
                    check(absr(got - want) < 1.0 / 32768.0,
                          (a < 16384 || a >= 32768) ? "R5" : "R2", "root", got, want);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: strobes low while reset is held
        check(out_valid == 1'b0 && lk_valid == 1'b0, "R8", "strobes in reset",
              real'(out_valid), 0.0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && lk_valid == 1'b0, "R8", "strobes after reset",
              real'(out_valid), 0.0);

        // R8: reset with arguments in flight
        send(20000);
        send(24000);
        send(30000);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        qo_arg.delete(); qo_cyc.delete();
        ql_arg.delete(); ql_cyc.delete();
        n_in = 0; n_out = 0;
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0 && lk_valid == 1'b0, "R8", "flushed strobe",
                  real'(out_valid), 0.0);
        end

        // R1-R7 sweep over every code, with irregular idle cycles (R7)
        for (int x = 0; x < 65536; x++) begin
            if ((x % 13) == 5 || (x % 97) == 40) idle();
            send(x);
        end
        idle();
        repeat (8) @(negedge clk);

        check(qo_arg.size() == 0 && ql_arg.size() == 0, "R7", "pending results",
              real'(qo_arg.size()), 0.0);
        check(n_out == n_in, "R7", "result count", real'(n_out), real'(n_in));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule